// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog built around a 35-bit down-counter. Enabling it loads the first preload value, and the counter runs in stage one. If the host does not restart it before the count runs out, the block pulses an interrupt line, loads the second preload value and enters stage two. If stage two also runs out, an active-low timeout output is asserted and a sticky timeout flag is set. The counter advances only on prescale tick strobes, which come from outside the block. One of two tick inputs is selected, fine or coarse, so a single counter covers resolutions from microseconds to minutes.

The host reaches the block through a flat write port and a combinational read port, each with a 3-bit address. Restarting the timer and changing either preload are protected writes. Each one must follow a two-write key sequence on the lock register. A new preload value does not disturb the running count. It is used the next time its stage is entered.

Top module: `twoStageWdog`

## Requirements
- R1: Reset state. The timeout output is high, the interrupt is low, the count reads 0, the status reads 0 and both preloads read their reset parameters. The read addresses are 0 first preload, 1 second preload, 2 config, 3 lock, 4 restart, 5 status and 6 count.
- R2: Config bit 0 is the enable. One cycle after a write sets it, the counter holds the first preload. From then on it drops by one for each selected tick. A stage runs out on a selected tick that finds the count at zero, so with a tick on every cycle the interrupt is high in cycle P1+2 after the config write edge.
- R3: When stage one runs out, the interrupt is high for exactly one cycle, the counter takes the second preload and status bit 1 (stage two) is set.
- R4: When stage two runs out, the timeout output goes low and status bit 0 (sticky flag) is set. The counter takes the second preload again and stays in stage two, so each later expiry comes P2+1 ticks after the previous one.
- R5: With config bit 1 clear, the timeout output stays low until reset once it has gone low.
- R6: With config bit 1 set, every stage-two expiry inverts the timeout output.
- R7: Writing 0x80 and then 0x86 to address 3 unlocks the block; only the low 8 bits are compared. Any other lock write, or the second key out of order, returns the block to locked. Reading address 3 returns 1 in bit 0 while unlocked.
- R8: Writes to address 0, 1 or 4 are ignored while locked. The next such write uses up an unlock, whether or not that write takes effect.
- R9: An unlocked write with bit 0 set to address 4 while running restarts the block. It enters stage one with the first preload, cancels stage two, and wins over an expiry in the same cycle.
- R10: Writing a preload does not change the running count. The new value is loaded on the next entry into its stage.
- R11: Writing 1 to bit 0 of address 5 clears the sticky flag.
- R12: While config bit 0 is clear, the count holds and status bit 2 (running) reads 0. Setting the bit again reloads the first preload.
- R13: Config bit 2 selects the coarse tick input; when it is clear, the fine tick input is used. Ticks on the other input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fineTick | input | 1 | Fine prescale tick strobe |
| coarseTick | input | 1 | Coarse prescale tick strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | CNT_W | Read data (combinational) |
| irq | output | 1 | One-cycle pulse at the end of stage one |
| toutN | output | 1 | Active-low timeout output |

## Verification
The main timing path is swept over every pair of first preload 0..4 and second preload 0..3, with a tick on every cycle. This exposes any off-by-one in either stage separately, since the interrupt delay depends only on P1 and the timeout delay depends only on P2. Single hand-driven ticks then probe the restart and unlock paths. Each key sequence is tried correctly, broken and reused. This separates an ignored write from an accepted one by reading back the count and preloads. Ticks are applied on the unselected input and while disabled, and the count is checked for no movement.

// File: rtl/wdogPkg.sv
package wdogPkg;
  typedef enum logic [1:0] {STG_OFF, STG_ONE, STG_TWO} stage_e;
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic countDown;
  } cntStrobe_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_PRE1   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE2   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LOCK   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd6;
endpackage

// File: rtl/wdogUnlock.sv
module wdogUnlock
  import wdogPkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h80,
  parameter logic [7:0] KEY_SECOND = 8'h86
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockWr,
  input  logic      protWr,
  input  logic [7:0] keyByte,
  output logic      unlocked,
  output unlock_e   unlockState
);
  unlock_e stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= UL_IDLE;
    end else if (lockWr) begin
      if (keyByte == KEY_FIRST)                           stateQ <= UL_HALF;
      else if (stateQ == UL_HALF && keyByte == KEY_SECOND) stateQ <= UL_OPEN;
      else                                                 stateQ <= UL_IDLE;
    end else if (protWr) begin
      stateQ <= UL_IDLE;
    end
  end

  assign unlocked    = (stateQ == UL_OPEN);
  assign unlockState = stateQ;
endmodule

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] preFirst,
  input  logic [CNT_W-1:0] preSecond,
  input  logic             fineTick,
  input  logic             coarseTick,
  input  logic             coarseSel,
  output logic [CNT_W-1:0] count,
  output logic             cntZero,
  output logic             tickNow
);
  logic [CNT_W-1:0] countQ;

  assign tickNow = coarseSel ? coarseTick : fineTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  countQ <= '0;
    else if (strobe.loadFirst)  countQ <= preFirst;
    else if (strobe.loadSecond) countQ <= preSecond;
    else if (strobe.countDown)  countQ <= countQ - 1'b1;
  end

  assign count   = countQ;
  assign cntZero = (countQ == '0);
endmodule

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
#(
  parameter int               CNT_W    = 35,
  parameter logic [CNT_W-1:0] PRE1_RST = 35'd1000,
  parameter logic [CNT_W-1:0] PRE2_RST = 35'd1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              unlocked,
  input  logic              cntZero,
  input  logic              tickNow,
  input  logic [CNT_W-1:0]  count,
  output logic              lockWr,
  output logic              protWr,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  preFirst,
  output logic [CNT_W-1:0]  preSecond,
  output logic              cfgEnable,
  output logic              cfgToggle,
  output logic              cfgCoarse,
  output logic              irq,
  output logic              toutN,
  output logic              timeoutFlag,
  output stage_e            stage
);
  logic   accept, reloadReq, expFirst, expSecond, clearReq;
  stage_e stageNext;

  assign lockWr   = wrEn && (wrAddr == ADDR_LOCK);
  assign protWr   = wrEn && (wrAddr == ADDR_PRE1 || wrAddr == ADDR_PRE2 ||
                             wrAddr == ADDR_RELOAD);
  assign accept   = protWr && unlocked;
  assign reloadReq = accept && (wrAddr == ADDR_RELOAD) && wrData[0] &&
                     cfgEnable && (stage != STG_OFF);
  assign clearReq = wrEn && (wrAddr == ADDR_STATUS) && wrData[0];

  // host registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preFirst  <= PRE1_RST;
      preSecond <= PRE2_RST;
      cfgEnable <= 1'b0;
      cfgToggle <= 1'b0;
      cfgCoarse <= 1'b0;
    end else begin
      if (accept && wrAddr == ADDR_PRE1) preFirst  <= wrData;
      if (accept && wrAddr == ADDR_PRE2) preSecond <= wrData;
      if (wrEn && wrAddr == ADDR_CFG) begin
        cfgEnable <= wrData[0];
        cfgToggle <= wrData[1];
        cfgCoarse <= wrData[2];
      end
    end
  end

  // stage sequencing
  always_comb begin
    stageNext = stage;
    strobe    = '0;
    expFirst  = 1'b0;
    expSecond = 1'b0;
    if (!cfgEnable) begin
      stageNext = STG_OFF;
    end else begin
      unique case (stage)
        STG_OFF: begin
          stageNext        = STG_ONE;
          strobe.loadFirst = 1'b1;
        end
        STG_ONE, STG_TWO: begin
          if (reloadReq) begin
            stageNext        = STG_ONE;
            strobe.loadFirst = 1'b1;
          end else if (tickNow) begin
            if (cntZero) begin
              stageNext         = STG_TWO;
              strobe.loadSecond = 1'b1;
              expFirst          = (stage == STG_ONE);
              expSecond         = (stage == STG_TWO);
            end else begin
              strobe.countDown = 1'b1;
            end
          end
        end
        default: stageNext = STG_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage       <= STG_OFF;
      irq         <= 1'b0;
      toutN       <= 1'b1;
      timeoutFlag <= 1'b0;
    end else begin
      stage <= stageNext;
      irq   <= expFirst;
      if (expSecond) toutN <= cfgToggle ? ~toutN : 1'b0;
      if (expSecond)     timeoutFlag <= 1'b1;
      else if (clearReq) timeoutFlag <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_PRE1:   rdData = preFirst;
      ADDR_PRE2:   rdData = preSecond;
      ADDR_CFG:    rdData[2:0] = {cfgCoarse, cfgToggle, cfgEnable};
      ADDR_LOCK:   rdData[0] = unlocked;
      ADDR_STATUS: rdData[2:0] = {stage != STG_OFF, stage == STG_TWO, timeoutFlag};
      ADDR_COUNT:  rdData = count;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/twoStageWdog.sv
module twoStageWdog
  import wdogPkg::*;
#(
  parameter int               CNT_W      = 35,
  parameter logic [CNT_W-1:0] PRE1_RST   = 35'd1000,
  parameter logic [CNT_W-1:0] PRE2_RST   = 35'd1000,
  parameter logic [7:0]       KEY_FIRST  = 8'h80,
  parameter logic [7:0]       KEY_SECOND = 8'h86
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fineTick,
  input  logic             coarseTick,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             irq,
  output logic             toutN
);
  cntStrobe_t       strobe;
  logic [CNT_W-1:0] preFirst, preSecond, count;
  logic             cntZero, tickNow, unlocked, lockWr, protWr;
  logic             cfgEnable, cfgToggle, cfgCoarse, timeoutFlag;
  stage_e           stage;
  unlock_e          unlockState;

  wdogUnlock #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) uUnlock (
    .clk(clk), .rstN(rstN), .lockWr(lockWr), .protWr(protWr),
    .keyByte(wrData[7:0]), .unlocked(unlocked), .unlockState(unlockState)
  );

  wdogCtrl #(.CNT_W(CNT_W), .PRE1_RST(PRE1_RST), .PRE2_RST(PRE2_RST)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .unlocked(unlocked), .cntZero(cntZero),
    .tickNow(tickNow), .count(count), .lockWr(lockWr), .protWr(protWr),
    .strobe(strobe), .preFirst(preFirst), .preSecond(preSecond),
    .cfgEnable(cfgEnable), .cfgToggle(cfgToggle), .cfgCoarse(cfgCoarse),
    .irq(irq), .toutN(toutN), .timeoutFlag(timeoutFlag), .stage(stage)
  );

  wdogDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preFirst(preFirst),
    .preSecond(preSecond), .fineTick(fineTick), .coarseTick(coarseTick),
    .coarseSel(cfgCoarse), .count(count), .cntZero(cntZero), .tickNow(tickNow)
  );
endmodule

// File: rtl/wdogChecker.sv
module wdogChecker
  import wdogPkg::*;
#(
  parameter int         CNT_W     = 35,
  parameter logic [7:0] KEY_FIRST = 8'h80
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             irq,
  input logic             toutN,
  input logic             timeoutFlag,
  input logic             cfgEnable,
  input logic             cfgToggle,
  input stage_e           stage,
  input unlock_e          unlockState,
  input logic [CNT_W-1:0] preFirst,
  input logic [CNT_W-1:0] count
);
  // R3
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R3
  irq_enters_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> stage == STG_TWO);
  // R4
  flag_with_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toutN) |-> timeoutFlag);
  // R5
  sticky_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!toutN && !cfgToggle) |=> !toutN);
  // R7
  broken_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_LOCK && wrData[7:0] != KEY_FIRST &&
     unlockState != UL_HALF) |=> unlockState == UL_IDLE);
  // R8
  locked_preload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_PRE1 && unlockState != UL_OPEN) |=> $stable(preFirst));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_RELOAD && wrData[0] && unlockState == UL_OPEN &&
     cfgEnable && stage != STG_OFF) |=> (stage == STG_ONE && count == $past(preFirst)));
  // R12
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> $stable(count));
endmodule

bind twoStageWdog wdogChecker #(.CNT_W(CNT_W), .KEY_FIRST(KEY_FIRST)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irq(irq), .toutN(toutN), .timeoutFlag(timeoutFlag), .cfgEnable(cfgEnable),
  .cfgToggle(cfgToggle), .stage(stage), .unlockState(unlockState),
  .preFirst(preFirst), .count(count)
);

// File: tb/tb_twoStageWdog.sv
module tb_twoStageWdog;
  localparam int W = 35;
  localparam logic [2:0] A_P1 = 3'd0, A_P2 = 3'd1, A_CFG = 3'd2, A_LOCK = 3'd3,
                         A_RLD = 3'd4, A_ST = 3'd5, A_CNT = 3'd6;

  logic clk = 1'b0, rstN = 1'b0, fineTick = 1'b0, coarseTick = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic irq, toutN;
  int checks = 0, fails = 0;

  twoStageWdog #(.CNT_W(W), .PRE1_RST(35'd50), .PRE2_RST(35'd25)) dut (
    .clk(clk), .rstN(rstN), .fineTick(fineTick), .coarseTick(coarseTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq), .toutN(toutN)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; fineTick = 1'b0; coarseTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic unlock();
    wr(A_LOCK, 35'h80);
    wr(A_LOCK, 35'h86);
  endtask

  task automatic pulseFine(input int n);
    for (int i = 0; i < n; i++) begin
      fineTick = 1'b1; @(negedge clk); fineTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulseCoarse(input int n);
    for (int i = 0; i < n; i++) begin
      coarseTick = 1'b1; @(negedge clk); coarseTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic waitToutLevel(input logic lvl, output int n);
    n = 0;
    while (toutN !== lvl && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    int n;
    doReset();
    @(negedge clk);
    // R1 reset state
    check("R1 toutN", toutN, 1);
    check("R1 irq", irq, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    rd(A_CNT, v); check("R1 count", v, 0);
    rd(A_P1, v);  check("R1 pre1", v, 50);
    rd(A_P2, v);  check("R1 pre2", v, 25);

    // R2 R3 R4 R5 sweep with a tick every cycle
    for (int p1 = 0; p1 < 5; p1++) begin
      for (int p2 = 0; p2 < 4; p2++) begin
        doReset();
        @(negedge clk);
        fineTick = 1'b1;
        unlock(); wr(A_P1, p1);
        unlock(); wr(A_P2, p2);
        wr(A_CFG, 35'd1);
        n = 0;
        while (irq !== 1'b1 && n < 500) begin @(negedge clk); n++; end
        check("R2 first stage length", n, p1 + 2);
        rd(A_ST, v); check("R3 stage two entered", v[1], 1);
        n = 0;
        while (toutN !== 1'b0 && n < 500) begin
          @(negedge clk); n++;
          if (n == 1) check("R3 interrupt one cycle", irq, 0);
        end
        check("R4 second stage length", n, p2 + 1);
        rd(A_ST, v); check("R4 sticky flag", v[0], 1);
        repeat (3 * (p2 + 1) + 2) @(negedge clk);
        check("R5 output stays low", toutN, 0);
      end
    end
    // R11 flag clear
    fineTick = 1'b0;
    wr(A_CFG, 35'd0);
    wr(A_ST, 35'd1);
    rd(A_ST, v); check("R11 flag cleared", v[0], 0);
    check("R5 still low after clear", toutN, 0);

    // R6 toggle mode
    doReset();
    @(negedge clk);
    fineTick = 1'b1;
    unlock(); wr(A_P1, 35'd1);
    unlock(); wr(A_P2, 35'd2);
    wr(A_CFG, 35'd3);
    waitToutLevel(1'b0, n);
    waitToutLevel(1'b1, n); check("R6 toggles high", n, 3);
    waitToutLevel(1'b0, n); check("R6 toggles low", n, 3);
    fineTick = 1'b0;

    // R2 R7 R8 R9 R10 R12 R13 with hand-driven ticks
    doReset();
    @(negedge clk);
    unlock(); wr(A_P1, 35'd20);
    unlock(); wr(A_P2, 35'd7);
    wr(A_CFG, 35'd1);
    @(negedge clk);
    rd(A_CNT, v); check("R2 load first preload", v, 20);
    pulseFine(5);
    rd(A_CNT, v); check("R2 one step per tick", v, 15);
    pulseCoarse(4);
    rd(A_CNT, v); check("R13 coarse ignored", v, 15);
    wr(A_RLD, 35'd1);
    rd(A_CNT, v); check("R8 locked restart ignored", v, 15);
    unlock();
    rd(A_LOCK, v); check("R7 unlocked flag", v, 1);
    wr(A_RLD, 35'd1);
    rd(A_CNT, v); check("R9 restart loads first", v, 20);
    rd(A_LOCK, v); check("R8 unlock used up", v, 0);
    unlock(); wr(A_P1, 35'd9);
    rd(A_CNT, v); check("R10 count undisturbed", v, 20);
    rd(A_P1, v);  check("R10 preload stored", v, 9);
    pulseFine(2);
    unlock(); wr(A_RLD, 35'd1);
    rd(A_CNT, v); check("R10 new preload on restart", v, 9);
    pulseFine(1);
    wr(A_LOCK, 35'h80); wr(A_LOCK, 35'h12); wr(A_LOCK, 35'h86);
    wr(A_RLD, 35'd1);
    rd(A_CNT, v); check("R7 broken order rejected", v, 8);
    unlock(); wr(A_P2, 35'd3); wr(A_P1, 35'd30);
    rd(A_P2, v); check("R8 first write accepted", v, 3);
    rd(A_P1, v); check("R8 second write rejected", v, 9);
    wr(A_CFG, 35'd5);
    pulseCoarse(3); pulseFine(2);
    rd(A_CNT, v); check("R13 coarse selected", v, 5);
    wr(A_CFG, 35'd1);
    // R9 restart from stage two
    unlock(); wr(A_P2, 35'd40);
    fineTick = 1'b1;
    n = 0;
    while (irq !== 1'b1 && n < 500) begin @(negedge clk); n++; end
    fineTick = 1'b0;
    rd(A_ST, v); check("R3 in stage two", v[1], 1);
    rd(A_CNT, v); check("R10 second preload used on entry", v, 40);
    unlock(); wr(A_RLD, 35'd1);
    rd(A_ST, v);  check("R9 back to stage one", v[1], 0);
    rd(A_CNT, v); check("R9 count reloaded", v, 9);
    check("R9 no timeout", toutN, 1);
    // R12 disable
    pulseFine(2);
    wr(A_CFG, 35'd0);
    pulseFine(3);
    rd(A_CNT, v); check("R12 count holds", v, 7);
    rd(A_ST, v);  check("R12 not running", v[2], 0);
    wr(A_CFG, 35'd1);
    @(negedge clk);
    rd(A_CNT, v); check("R12 re-enable reloads", v, 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule